// File: doc/BRIEF.md
# Rate-Sized Serial Word Transmitter

The block takes finished code words from an upstream coder and shifts each one out on a single serial data line. A producer pushes a word together with its rate code through a load strobe into a two-entry holding buffer. A word that was written during one frame is sent in a later frame, so the slot being transmitted and the slot being refilled never collide. The far end frames the transfer with an output enable and supplies the data clock. The block counts falling clock edges under the enable to start a frame. The first bit appears on the following rising edge, and later bits follow on later rising edges. Each bit is therefore stable when the receiver samples it on a falling edge.

The rate code sets how many bits leave the block, and only the right-aligned low bits of the stored word are sent. Two timing styles are supported. A short-frame enable marks a single falling edge and then drops. A long-frame enable stays high across the word. When the enable is low by the time the last bit ends, that bit is cut to half a clock period. When the enable is still high at that point, the last bit is held for a full period and the word is sent again from its first bit, repeatedly, until the enable falls.

The data clock and the enable are sampled into the system clock domain through a synchronizer. The transmitter is a six-state machine:

- ST_IDLE: no frame is in progress.
- ST_ARMED: a word has been taken from the buffer and waits for the first rising edge.
- ST_SHIFT: the first pass through the word.
- ST_LSB: the last bit is on the line and the block waits for the falling edge that decides its length.
- ST_HOLD: the last bit has been stretched to a full period.
- ST_REPEAT: a repeat pass through the word.

The transitions are:

- arm (IDLE to ARMED): a falling edge with the enable high, a fresh enable and a word waiting.
- start (ARMED to SHIFT): a rising edge.
- step (SHIFT or REPEAT to itself): a rising edge while more than one bit remains.
- last (SHIFT or REPEAT to LSB): a rising edge that puts bit 0 on the line.
- cut (LSB to IDLE): a falling edge with the enable low.
- stretch (LSB to HOLD): a falling edge with the enable high.
- again (HOLD to REPEAT): a rising edge with the enable high.
- stop (HOLD or REPEAT to IDLE): a rising edge with the enable low.

Top module: `ser_out_tx`

## Requirements
- R1: While reset is applied and right after it is released, `sdo` is 0 and `busy` is 0.
- R2: The rate code selects the bit count: 2'b00 sends 8 bits, 2'b01 sends 4, 2'b10 sends 3 and 2'b11 sends 2. The word is right-aligned in `load_code`, it is sent from bit count-1 down to bit 0, and higher bits are never sent.
- R3: A frame is armed on the first falling data-clock edge that sees `oe` high after `oe` was low. The first bit appears on the next rising edge, every later bit changes on a rising edge, and each bit holds its value across the following falling edge.
- R4: If `oe` drops before the last bit has been sent, the remaining bits are still sent. The last bit then ends at the next falling edge, where `sdo` returns to 0 (half a clock period).
- R5: A short-frame enable, high across exactly one falling edge, sends the whole word, and its last bit lasts half a period.
- R6: If `oe` is still high at the falling edge inside the last bit, that bit is held for a full period. The word then restarts from its first bit on the next rising edge and keeps repeating while `oe` stays high.
- R7: Once a repeat has begun, the first rising edge that finds `oe` low ends the frame with `sdo` at 0.
- R8: Words leave the two-entry holding buffer in the order they were loaded. A load that arrives while both entries are occupied is discarded.
- R9: An enable frame that finds no word waiting leaves `sdo` at 0 and `busy` at 0 throughout.
- R10: `busy` is 1 from the arm transition until the frame ends, and is 0 after it.
- R11: `sdo` changes only in the cycle after a synchronized data-clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| load | input | 1 | Strobe that writes one word into the holding buffer |
| load_code | input | 8 | Code word, right-aligned |
| load_rate | input | 2 | Rate code of the word (see R2) |
| dclk | input | 1 | Serial data clock supplied by the receiver |
| oe | input | 1 | Output enable that frames a transfer |
| sdo | output | 1 | Serial data out, 0 when idle |
| busy | output | 1 | High while a frame is in progress |

## Verification
The bench targets the length of the last bit. It drops the enable before the last bit, right at the last bit's rising edge, and leaves it high past it. A design that picks the wrong edge for this decision either cuts a repeat that should happen or keeps driving a stale bit after the enable is gone. Repeat passes are checked for two- and three-bit words, where an off-by-one index would restart at the wrong bit or skip the stretched period. A third load into a full buffer and a frame with an empty buffer expose a design that overwrites a waiting word or sends garbage when nothing is queued. Each rate is sent with non-zero upper bits so that a wrong bit count leaks them onto the line.

// File: rtl/ser_pkg.sv
package ser_pkg;

    localparam int CODE_W = 8;
    localparam int IDX_W  = $clog2(CODE_W);

    typedef enum logic [1:0] {
        RATE_64K = 2'b00,
        RATE_32K = 2'b01,
        RATE_24K = 2'b10,
        RATE_16K = 2'b11
    } rate_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ARMED,
        ST_SHIFT,
        ST_LSB,
        ST_HOLD,
        ST_REPEAT
    } tx_state_e;

    typedef struct packed {
        rate_e              rate;
        logic [CODE_W-1:0]  code;
    } entry_t;

    // index of the first bit sent for a rate
    function automatic logic [IDX_W-1:0] top_index(input rate_e r);
        logic [IDX_W-1:0] t;
        unique case (r)
            RATE_64K: t = IDX_W'(7);
            RATE_32K: t = IDX_W'(3);
            RATE_24K: t = IDX_W'(2);
            RATE_16K: t = IDX_W'(1);
            default:  t = IDX_W'(7);
        endcase
        return t;
    endfunction

endpackage

// File: rtl/ser_edge_sync.sv
module ser_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic dclk_in,
    input  logic oe_in,
    output logic dclk_rise,
    output logic dclk_fall,
    output logic oe_lvl
);
    localparam int CH = 2;

    logic [STAGES-1:0] chain [CH];
    logic              dclk_prev;
    logic [CH-1:0]     raw;

    assign raw = {oe_in, dclk_in};

    for (genvar c = 0; c < CH; c++) begin : g_chan
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                chain[c] <= '0;
            end else begin
                chain[c] <= {chain[c][STAGES-2:0], raw[c]};
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dclk_prev <= 1'b0;
        end else begin
            dclk_prev <= chain[0][STAGES-1];
        end
    end

    assign dclk_rise = chain[0][STAGES-1] & ~dclk_prev;
    assign dclk_fall = ~chain[0][STAGES-1] & dclk_prev;
    assign oe_lvl    = chain[1][STAGES-1];

endmodule

// File: rtl/ser_hold_buf.sv
module ser_hold_buf #(
    parameter int W     = 10,
    parameter int DEPTH = 2
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       push,
    input  logic [W-1:0]               din,
    input  logic                       pop,
    output logic [W-1:0]               dout,
    output logic                       empty,
    output logic                       full,
    output logic [$clog2(DEPTH+1)-1:0] count
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH+1);

    logic [W-1:0]     mem [DEPTH];
    logic [PTR_W-1:0] wr_ptr, rd_ptr;
    logic             do_push, do_pop;

    assign empty   = (count == '0);
    assign full    = (count == CNT_W'(DEPTH));
    assign do_push = push & ~full;
    assign do_pop  = pop & ~empty;
    assign dout    = mem[rd_ptr];

    function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH-1)) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (do_push) wr_ptr <= bump(wr_ptr);
            if (do_pop)  rd_ptr <= bump(rd_ptr);
            unique case ({do_push, do_pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    for (genvar i = 0; i < DEPTH; i++) begin : g_slot
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                mem[i] <= '0;
            end else if (do_push && wr_ptr == PTR_W'(i)) begin
                mem[i] <= din;
            end
        end
    end

endmodule

// File: rtl/ser_tx_fsm.sv
module ser_tx_fsm
    import ser_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      dclk_rise,
    input  logic      dclk_fall,
    input  logic      oe_lvl,
    input  logic      have_word,
    input  entry_t    head,
    output logic      pop,
    output logic      sdo,
    output logic      busy,
    output tx_state_e state
);
    tx_state_e         nxt;
    logic [CODE_W-1:0] shreg;
    logic [IDX_W-1:0]  top;
    logic [IDX_W-1:0]  idx;
    logic              fresh;
    logic              go;

    assign go   = (state == ST_IDLE) && dclk_fall && oe_lvl && fresh && have_word;
    assign pop  = go;
    assign busy = (state != ST_IDLE);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    // transitions
    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:   if (go) nxt = ST_ARMED;
            ST_ARMED:  if (dclk_rise) nxt = (top == '0) ? ST_LSB : ST_SHIFT;
            ST_SHIFT:  if (dclk_rise && idx == IDX_W'(1)) nxt = ST_LSB;
            ST_REPEAT: begin
                if (dclk_rise) begin
                    if (!oe_lvl)              nxt = ST_IDLE;
                    else if (idx == IDX_W'(1)) nxt = ST_LSB;
                end
            end
            ST_LSB:    if (dclk_fall) nxt = oe_lvl ? ST_HOLD : ST_IDLE;
            ST_HOLD: begin
                if (dclk_rise) begin
                    if (!oe_lvl)        nxt = ST_IDLE;
                    else if (top == '0) nxt = ST_LSB;
                    else                nxt = ST_REPEAT;
                end
            end
            default:   nxt = ST_IDLE;
        endcase
    end

    // outputs and word datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sdo   <= 1'b0;
            shreg <= '0;
            top   <= '0;
            idx   <= '0;
            fresh <= 1'b0;
        end else begin
            if (!oe_lvl)                                   fresh <= 1'b1;
            else if (state == ST_IDLE && dclk_fall)        fresh <= 1'b0;

            unique case (state)
                ST_IDLE: begin
                    sdo <= 1'b0;
                    if (go) begin
                        shreg <= head.code;
                        top   <= top_index(head.rate);
                    end
                end
                ST_ARMED: begin
                    if (dclk_rise) begin
                        idx <= top;
                        sdo <= shreg[top];
                    end
                end
                ST_SHIFT, ST_REPEAT: begin
                    if (dclk_rise) begin
                        if (state == ST_REPEAT && !oe_lvl) begin
                            sdo <= 1'b0;
                        end else begin
                            idx <= idx - 1'b1;
                            sdo <= shreg[idx - 1'b1];
                        end
                    end
                end
                ST_LSB: begin
                    if (dclk_fall && !oe_lvl) sdo <= 1'b0;
                end
                ST_HOLD: begin
                    if (dclk_rise) begin
                        if (oe_lvl) begin
                            idx <= top;
                            sdo <= shreg[top];
                        end else begin
                            sdo <= 1'b0;
                        end
                    end
                end
                default: sdo <= 1'b0;
            endcase
        end
    end

endmodule

// File: rtl/ser_out_tx.sv
module ser_out_tx
    import ser_pkg::*;
#(
    parameter int BUF_DEPTH   = 2,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [CODE_W-1:0] load_code,
    input  logic [1:0]        load_rate,
    input  logic              dclk,
    input  logic              oe,
    output logic              sdo,
    output logic              busy
);
    localparam int ENT_W = $bits(entry_t);
    localparam int CNT_W = $clog2(BUF_DEPTH+1);

    logic             dclk_rise, dclk_fall, oe_lvl;
    logic             buf_empty, buf_full, buf_pop;
    logic [CNT_W-1:0] buf_count;
    logic [ENT_W-1:0] buf_out;
    entry_t           in_entry, head;
    tx_state_e        tx_state;

    assign in_entry.rate = rate_e'(load_rate);
    assign in_entry.code = load_code;
    assign head          = entry_t'(buf_out);

    ser_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .dclk_in   (dclk),
        .oe_in     (oe),
        .dclk_rise (dclk_rise),
        .dclk_fall (dclk_fall),
        .oe_lvl    (oe_lvl)
    );

    ser_hold_buf #(.W(ENT_W), .DEPTH(BUF_DEPTH)) u_buf (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (load),
        .din   (in_entry),
        .pop   (buf_pop),
        .dout  (buf_out),
        .empty (buf_empty),
        .full  (buf_full),
        .count (buf_count)
    );

    ser_tx_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .dclk_rise (dclk_rise),
        .dclk_fall (dclk_fall),
        .oe_lvl    (oe_lvl),
        .have_word (~buf_empty),
        .head      (head),
        .pop       (buf_pop),
        .sdo       (sdo),
        .busy      (busy),
        .state     (tx_state)
    );

endmodule

// File: rtl/ser_out_chk.sv
module ser_out_chk
    import ser_pkg::*;
#(
    parameter int DEPTH = 2
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic                       sdo,
    input logic                       busy,
    input logic                       dclk_rise,
    input logic                       dclk_fall,
    input logic                       oe_lvl,
    input tx_state_e                  state,
    input logic                       push,
    input logic                       pop,
    input logic                       full,
    input logic [$clog2(DEPTH+1)-1:0] count
);
    // R11
    sdo_edge_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sdo != $past(sdo)) |-> $past(dclk_rise || dclk_fall));

    // R9
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !sdo);

    // R8
    buf_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        count <= ($clog2(DEPTH+1))'(DEPTH));

    // R8
    full_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (full && push && !pop) |=> (count == $past(count)));

    // R4
    lsb_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_LSB && !dclk_fall) |=> (state == ST_LSB));

    // R7
    repeat_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_REPEAT && dclk_rise && !oe_lvl) |=> (state == ST_IDLE && !sdo));

endmodule

bind ser_out_tx ser_out_chk #(.DEPTH(BUF_DEPTH)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .sdo       (sdo),
    .busy      (busy),
    .dclk_rise (dclk_rise),
    .dclk_fall (dclk_fall),
    .oe_lvl    (oe_lvl),
    .state     (tx_state),
    .push      (load),
    .pop       (buf_pop),
    .full      (buf_full),
    .count     (buf_count)
);

// File: tb/sim_ser_out_tx.sv
module sim_ser_out_tx;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       load = 1'b0;
    logic [7:0] load_code = '0;
    logic [1:0] load_rate = '0;
    logic       dclk = 1'b1;
    logic       oe = 1'b0;
    logic       sdo, busy;

    int n_cmp = 0;
    int n_bad = 0;
    bit ended = 1'b0;

    always #2.5 clk = ~clk;

    ser_out_tx u0 (
        .clk(clk), .rst_n(rst_n), .load(load), .load_code(load_code),
        .load_rate(load_rate), .dclk(dclk), .oe(oe), .sdo(sdo), .busy(busy)
    );

    task automatic wait_clks(input int k);
        repeat (k) @(posedge clk);
        #1;
    endtask

    task automatic chk(input string req, input logic got, input logic exp);
        n_cmp++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s got=%0b exp=%0b at %0t", req, got, exp, $time);
        end
    endtask

    task automatic rise_edge();
        dclk = 1'b1;
        wait_clks(10);
    endtask

    task automatic fall_edge();
        dclk = 1'b0;
        wait_clks(10);
    endtask

    task automatic push_word(input logic [7:0] w, input logic [1:0] r);
        load_code = w;
        load_rate = r;
        load      = 1'b1;
        wait_clks(1);
        load      = 1'b0;
        wait_clks(1);
    endtask

    // drop_rise: oe goes low just before this rising edge (1 = short frame)
    task automatic run_frame(input string req, input logic [7:0] w, input int n,
                             input int drop_rise);
        bit done = 1'b0;
        int r = 1;
        oe = 1'b1;
        fall_edge();                      // arm (R3)
        while (!done) begin
            if (r >= drop_rise) oe = 1'b0;
            rise_edge();
            if (r == 1) chk({req, " R10 busy during frame"}, busy, 1'b1);
            if (r > n && !oe) begin
                chk({req, " R7 stop on rise"}, sdo, 1'b0);
                done = 1'b1;
            end else begin
                int idx = n - 1 - ((r - 1) % n);
                chk({req, " R3 bit after rise"}, sdo, w[idx]);
                fall_edge();
                if (idx == 0 && !oe) begin
                    chk({req, " R4 half lsb"}, sdo, 1'b0);
                    done = 1'b1;
                end else begin
                    chk({req, " R6 bit held over fall"}, sdo, w[idx]);
                end
            end
            r++;
        end
        oe = 1'b0;
        if (dclk == 1'b0) rise_edge();
        chk({req, " R10 busy after frame"}, busy, 1'b0);
        chk({req, " R10 line idle"}, sdo, 1'b0);
    endtask

    task automatic t_reset();
        wait_clks(3);
        chk("R1 sdo in reset", sdo, 1'b0);
        chk("R1 busy in reset", busy, 1'b0);
        rst_n = 1'b1;
        wait_clks(3);
        chk("R1 sdo after reset", sdo, 1'b0);
        chk("R1 busy after reset", busy, 1'b0);
        rise_edge();
    endtask

    task automatic t_rates();
        push_word(8'hA5, 2'b00);
        run_frame("R2 64k", 8'hA5, 8, 8);
        push_word(8'hF6, 2'b01);
        run_frame("R2 32k", 8'hF6, 4, 4);
        push_word(8'hFD, 2'b10);
        run_frame("R2 24k", 8'hFD, 3, 3);
        push_word(8'hFE, 2'b11);
        run_frame("R2 16k", 8'hFE, 2, 2);
    endtask

    task automatic t_early_drop();
        push_word(8'h3C, 2'b00);
        run_frame("R4 early drop", 8'h3C, 8, 3);
    endtask

    task automatic t_short();
        push_word(8'h09, 2'b01);
        run_frame("R5 short frame", 8'h09, 4, 1);
    endtask

    task automatic t_repeat();
        push_word(8'h06, 2'b10);
        run_frame("R6 repeat 24k", 8'h06, 3, 8);
        push_word(8'h01, 2'b11);
        run_frame("R7 stop after stretch", 8'h01, 2, 5);
    endtask

    task automatic t_buffer();
        push_word(8'h5A, 2'b00);
        push_word(8'h0B, 2'b01);
        push_word(8'hFF, 2'b00);          // dropped: buffer full
        run_frame("R8 first out", 8'h5A, 8, 8);
        run_frame("R8 second out", 8'h0B, 4, 4);
        oe = 1'b1;
        fall_edge();
        chk("R9 no word busy", busy, 1'b0);
        rise_edge();
        chk("R8 third dropped sdo", sdo, 1'b0);
        fall_edge();
        chk("R9 empty frame sdo", sdo, 1'b0);
        oe = 1'b0;
        rise_edge();
        chk("R9 empty frame busy", busy, 1'b0);
    endtask

    initial begin
        t_reset();
        t_rates();
        t_early_drop();
        t_short();
        t_repeat();
        t_buffer();
        if (!ended) begin
            ended = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!ended) begin
            ended = 1'b1;
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog got=hung exp=done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule